// File: doc/BRIEF.md
# Fused-Style Multiply-Add Exception Sequencer

This block controls a floating-point multiply-add class operation that is done as two steps, each rounded on its own. It accepts one of four operation variants together with three operands and a trap-enable mask. It sends the two factors to an external multiplier and reads back the rounded product and its five exception flags. If none of those flags is enabled for trapping, it sends the product and the addend to an external adder. With that request it drives two sign controls, one to negate the product and one to negate the addend, which together select the variant.

When the add step returns, the block settles the exception state and ends the operation in one of two ways.
- **Normal completion:** the non-trapping flags of both steps are merged into a current-exception field, and that field is accumulated into a sticky accrued-exception field. The result is presented with a one-cycle write-enable pulse.
- **Trap:** only the trapping condition is written into the current field, the accrued field is left as it was, no write enable is given, and a one-cycle trap pulse is raised. A trapping multiply step aborts the operation before the add step is issued.

The multiplier and adder are request/response ports. A request is a one-cycle pulse. A response is a one-cycle valid carrying a result and flags, and it may come any number of cycles later, including in the request cycle itself.

Top module: `fma_seq`

## Requirements
- R1: A new operation is accepted on `op_valid` only while `op_ready` is high, which holds only when the block is idle. The cycle after acceptance, `mul_req` pulses for exactly one cycle with `mul_a`/`mul_b` equal to the accepted `op_a`/`op_b`. Any `op_valid` seen while busy is ignored.
- R2: `op_kind` encodes the variant, and the add request carries these sign controls:
  - 00 is a*b+c: `add_neg_prod`=0, `add_neg_addend`=0.
  - 01 is a*b-c: `add_neg_prod`=0, `add_neg_addend`=1.
  - 10 is -(a*b)-c: `add_neg_prod`=1, `add_neg_addend`=1.
  - 11 is -(a*b)+c: `add_neg_prod`=1, `add_neg_addend`=0.
- R3: `add_req` pulses for one cycle, in the cycle after a multiply response that has no trapping flag. `add_x` equals the returned product unchanged, since the product is already rounded, and `add_y` equals the accepted `op_c`.
- R4: A multiply response with a trapping flag causes the following:
  - no add request is issued;
  - `trap` pulses in the next cycle;
  - `exc_cur` becomes exactly the trapping bits of the multiply flags;
  - `exc_acc` is unchanged.
- R5: An add response with a trapping flag, after a clean multiply, causes the following:
  - `exc_cur` becomes exactly the trapping bits of the add flags, so the multiply's non-trapping flags are discarded;
  - `exc_acc` is unchanged;
  - `trap` pulses in the next cycle.
- R6: When neither step traps, `exc_cur` becomes the OR of both steps' flags, and `exc_acc` becomes its previous value ORed with that new `exc_cur`. `done` pulses in the cycle after the add response.
- R7: `rd_we` pulses for exactly one cycle with `rd_data` equal to the add result on normal completion. It is never high on a trap.
- R8: Each flag vector has 5 bits: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. A condition traps when its flag and the trap-enable bit at the same position are both set. The trap-enable mask is sampled at acceptance.
- R9: Responses that arrive when the block is not waiting for them are ignored and do not change `exc_cur`, `exc_acc`, `trap`, `done` or the request outputs. This covers responses while idle, and add responses while waiting on the multiply.
- R10: After reset, `op_ready` is high, `exc_cur` and `exc_acc` are zero, and `mul_req`, `add_req`, `rd_we`, `done` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | New operation offered |
| op_ready | output | 1 | Block idle, operation can be accepted |
| op_kind | input | 2 | Variant select (see R2) |
| op_a | input | DATA_W | First factor |
| op_b | input | DATA_W | Second factor |
| op_c | input | DATA_W | Addend |
| trap_en | input | 5 | Trap-enable mask, same bit order as flags |
| mul_req | output | 1 | Multiply request pulse |
| mul_a | output | DATA_W | Multiply operand a |
| mul_b | output | DATA_W | Multiply operand b |
| mul_rsp_valid | input | 1 | Multiply response valid |
| mul_rsp_result | input | DATA_W | Rounded product |
| mul_rsp_flags | input | 5 | Multiply exception flags |
| add_req | output | 1 | Add request pulse |
| add_x | output | DATA_W | Product operand to adder |
| add_y | output | DATA_W | Addend operand to adder |
| add_neg_prod | output | 1 | Adder negates product |
| add_neg_addend | output | 1 | Adder negates addend |
| add_rsp_valid | input | 1 | Add response valid |
| add_rsp_result | input | DATA_W | Rounded sum |
| add_rsp_flags | input | 5 | Add exception flags |
| rd_we | output | 1 | Destination write enable pulse |
| rd_data | output | DATA_W | Destination write data |
| done | output | 1 | Normal completion pulse |
| trap | output | 1 | Trap request pulse |
| exc_cur | output | 5 | Current-exception field |
| exc_acc | output | 5 | Accrued-exception field |

## Verification
The assertions check a set of properties on every cycle:
- requests follow acceptance;
- sign controls match the captured variant;
- an add request only follows a clean multiply response;
- a trap never coincides with a write enable;
- a trap leaves the accrued field stable and reports only enabled conditions;
- the accrued field never loses a bit.

Only the bench scenarios can show the exact contents of the current field after a trap or a merge, in particular that the multiply's non-trapping flags are dropped when the add step traps. The same holds for the returned data reaching the adder and the destination, and for stray responses and offers being ignored.

// File: rtl/fma_seq_pkg.sv
package fma_seq_pkg;

    // IEEE exception flag vector width and bit positions
    localparam int FLAG_W = 5;
    localparam int FLG_INVALID  = 4;
    localparam int FLG_OVERFLOW = 3;
    localparam int FLG_UNDERFLW = 2;
    localparam int FLG_DIVZERO  = 1;
    localparam int FLG_INEXACT  = 0;

    typedef enum logic [1:0] {
        OPK_MADD  = 2'b00,   // a*b + c
        OPK_MSUB  = 2'b01,   // a*b - c
        OPK_NMADD = 2'b10,   // -(a*b) - c
        OPK_NMSUB = 2'b11    // -(a*b) + c
    } op_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_MUL_WAIT = 3'd1,
        ST_ADD_WAIT = 3'd2,
        ST_DONE     = 3'd3,
        ST_TRAP     = 3'd4
    } seq_state_e;

endpackage

// File: rtl/fma_sign_ctl.sv
module fma_sign_ctl
    import fma_seq_pkg::*;
(
    input  op_kind_e kind,
    output logic     neg_prod,
    output logic     neg_addend
);

    always_comb begin
        unique case (kind)
            OPK_MADD:  begin neg_prod = 1'b0; neg_addend = 1'b0; end
            OPK_MSUB:  begin neg_prod = 1'b0; neg_addend = 1'b1; end
            OPK_NMADD: begin neg_prod = 1'b1; neg_addend = 1'b1; end
            OPK_NMSUB: begin neg_prod = 1'b1; neg_addend = 1'b0; end
            default:   begin neg_prod = 1'b0; neg_addend = 1'b0; end
        endcase
    end

endmodule

// File: rtl/fma_exc_merge.sv
module fma_exc_merge #(
    parameter int FLAG_W = 5
) (
    input  logic [FLAG_W-1:0] step_flags,
    input  logic [FLAG_W-1:0] prior_flags,
    input  logic [FLAG_W-1:0] trap_mask,
    output logic [FLAG_W-1:0] trap_bits,
    output logic              any_trap,
    output logic [FLAG_W-1:0] merged
);

    // a condition traps only when raised and enabled at the same position
    always_comb begin
        trap_bits = step_flags & trap_mask;
        any_trap  = |trap_bits;
        merged    = prior_flags | step_flags;
    end

endmodule

// File: rtl/fma_seq.sv
module fma_seq
    import fma_seq_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    output logic                 op_ready,
    input  logic [1:0]           op_kind,
    input  logic [DATA_W-1:0]    op_a,
    input  logic [DATA_W-1:0]    op_b,
    input  logic [DATA_W-1:0]    op_c,
    input  logic [FLAG_W-1:0]    trap_en,
    output logic                 mul_req,
    output logic [DATA_W-1:0]    mul_a,
    output logic [DATA_W-1:0]    mul_b,
    input  logic                 mul_rsp_valid,
    input  logic [DATA_W-1:0]    mul_rsp_result,
    input  logic [FLAG_W-1:0]    mul_rsp_flags,
    output logic                 add_req,
    output logic [DATA_W-1:0]    add_x,
    output logic [DATA_W-1:0]    add_y,
    output logic                 add_neg_prod,
    output logic                 add_neg_addend,
    input  logic                 add_rsp_valid,
    input  logic [DATA_W-1:0]    add_rsp_result,
    input  logic [FLAG_W-1:0]    add_rsp_flags,
    output logic                 rd_we,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 done,
    output logic                 trap,
    output logic [FLAG_W-1:0]    exc_cur,
    output logic [FLAG_W-1:0]    exc_acc
);

    typedef struct packed {
        seq_state_e          state;
        op_kind_e            kind;
        logic [DATA_W-1:0]   a;
        logic [DATA_W-1:0]   b;
        logic [DATA_W-1:0]   c;
        logic [FLAG_W-1:0]   en;
        logic [DATA_W-1:0]   prod;
        logic [FLAG_W-1:0]   mflags;
        logic [DATA_W-1:0]   result;
        logic [FLAG_W-1:0]   cur;
        logic [FLAG_W-1:0]   acc;
        logic                mul_req;
        logic                add_req;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [FLAG_W-1:0] mul_trap_bits, mul_merged;
    logic [FLAG_W-1:0] add_trap_bits, add_merged;
    logic              mul_any_trap, add_any_trap;

    // multiply step has no earlier flags to merge with
    fma_exc_merge #(.FLAG_W(FLAG_W)) u_mul_exc (
        .step_flags  (mul_rsp_flags),
        .prior_flags ({FLAG_W{1'b0}}),
        .trap_mask   (q.en),
        .trap_bits   (mul_trap_bits),
        .any_trap    (mul_any_trap),
        .merged      (mul_merged)
    );

    // add step merges on top of the stored clean multiply flags
    fma_exc_merge #(.FLAG_W(FLAG_W)) u_add_exc (
        .step_flags  (add_rsp_flags),
        .prior_flags (q.mflags),
        .trap_mask   (q.en),
        .trap_bits   (add_trap_bits),
        .any_trap    (add_any_trap),
        .merged      (add_merged)
    );

    fma_sign_ctl u_sign (
        .kind       (q.kind),
        .neg_prod   (add_neg_prod),
        .neg_addend (add_neg_addend)
    );

    always_comb begin
        d         = q;
        d.mul_req = 1'b0;
        d.add_req = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (op_valid) begin
                    d.state   = ST_MUL_WAIT;
                    d.kind    = op_kind_e'(op_kind);
                    d.a       = op_a;
                    d.b       = op_b;
                    d.c       = op_c;
                    d.en      = trap_en;
                    d.mul_req = 1'b1;
                end
            end
            ST_MUL_WAIT: begin
                if (mul_rsp_valid) begin
                    if (mul_any_trap) begin
                        // abort: add step never starts, accrued left alone
                        d.cur   = mul_trap_bits;
                        d.state = ST_TRAP;
                    end else begin
                        d.prod    = mul_rsp_result;
                        d.mflags  = mul_merged;
                        d.add_req = 1'b1;
                        d.state   = ST_ADD_WAIT;
                    end
                end
            end
            ST_ADD_WAIT: begin
                if (add_rsp_valid) begin
                    if (add_any_trap) begin
                        d.cur   = add_trap_bits;
                        d.state = ST_TRAP;
                    end else begin
                        d.result = add_rsp_result;
                        d.cur    = add_merged;
                        d.acc    = q.acc | add_merged;
                        d.state  = ST_DONE;
                    end
                end
            end
            ST_DONE, ST_TRAP: d.state = ST_IDLE;
            default:          d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state   <= ST_IDLE;
            q.kind    <= OPK_MADD;
            q.a       <= '0;
            q.b       <= '0;
            q.c       <= '0;
            q.en      <= '0;
            q.prod    <= '0;
            q.mflags  <= '0;
            q.result  <= '0;
            q.cur     <= '0;
            q.acc     <= '0;
            q.mul_req <= 1'b0;
            q.add_req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign op_ready = (q.state == ST_IDLE);
    assign mul_req  = q.mul_req;
    assign mul_a    = q.a;
    assign mul_b    = q.b;
    assign add_req  = q.add_req;
    assign add_x    = q.prod;
    assign add_y    = q.c;
    assign done     = (q.state == ST_DONE);
    assign rd_we    = (q.state == ST_DONE);
    assign rd_data  = q.result;
    assign trap     = (q.state == ST_TRAP);
    assign exc_cur  = q.cur;
    assign exc_acc  = q.acc;

endmodule

// File: rtl/fma_seq_chk.sv
module fma_seq_chk
    import fma_seq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic [1:0]        op_kind,
    input logic [FLAG_W-1:0] trap_en,
    input logic              mul_req,
    input logic              mul_rsp_valid,
    input logic [FLAG_W-1:0] mul_rsp_flags,
    input logic              add_req,
    input logic              add_neg_prod,
    input logic              add_neg_addend,
    input logic              add_rsp_valid,
    input logic              rd_we,
    input logic              done,
    input logic              trap,
    input logic [FLAG_W-1:0] exc_cur,
    input logic [FLAG_W-1:0] exc_acc
);

    logic [1:0]        kind_cap;
    logic [FLAG_W-1:0] en_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_cap <= '0;
            en_cap   <= '0;
        end else if (op_valid && op_ready) begin
            kind_cap <= op_kind;
            en_cap   <= trap_en;
        end
    end

    assert_req_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mul_req |-> $past(op_valid && op_ready));

    assert_sign_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        add_req |-> (add_neg_prod == kind_cap[1]) && (add_neg_addend == (kind_cap[1] ^ kind_cap[0])));

    assert_add_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        add_req |-> ($past(mul_rsp_valid) && (($past(mul_rsp_flags) & en_cap) == '0)));

    assert_trap_enabled_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> ((exc_cur != '0) && ((exc_cur & ~en_cap) == '0)));

    assert_acc_hold_on_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $stable(exc_acc));

    assert_acc_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((exc_acc & $past(exc_acc)) == $past(exc_acc)));

    assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((exc_cur & en_cap) == '0));

    assert_no_we_on_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_we && trap));

    assert_we_after_add_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we |-> $past(add_rsp_valid));

endmodule

bind fma_seq fma_seq_chk u_fma_seq_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_ready       (op_ready),
    .op_kind        (op_kind),
    .trap_en        (trap_en),
    .mul_req        (mul_req),
    .mul_rsp_valid  (mul_rsp_valid),
    .mul_rsp_flags  (mul_rsp_flags),
    .add_req        (add_req),
    .add_neg_prod   (add_neg_prod),
    .add_neg_addend (add_neg_addend),
    .add_rsp_valid  (add_rsp_valid),
    .rd_we          (rd_we),
    .done           (done),
    .trap           (trap),
    .exc_cur        (exc_cur),
    .exc_acc        (exc_acc)
);

// File: tb/tb_fma_seq.sv
module tb_fma_seq;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic          op_ready;
    logic [1:0]    op_kind = '0;
    logic [DW-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic [4:0]    trap_en = '0;
    logic          mul_req;
    logic [DW-1:0] mul_a, mul_b;
    logic          mul_rsp_valid = 1'b0;
    logic [DW-1:0] mul_rsp_result = '0;
    logic [4:0]    mul_rsp_flags = '0;
    logic          add_req;
    logic [DW-1:0] add_x, add_y;
    logic          add_neg_prod, add_neg_addend;
    logic          add_rsp_valid = 1'b0;
    logic [DW-1:0] add_rsp_result = '0;
    logic [4:0]    add_rsp_flags = '0;
    logic          rd_we;
    logic [DW-1:0] rd_data;
    logic          done, trap;
    logic [4:0]    exc_cur, exc_acc;

    int n_checks = 0;
    int n_errs   = 0;
    logic [4:0] exp_acc = '0;

    always #2 clk = ~clk;   // 250 MHz

    fma_seq #(.DATA_W(DW)) dut (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // sign controls from the variant table of R2
    function automatic logic [1:0] exp_signs(input logic [1:0] kind);
        case (kind)
            2'b00:   return 2'b00;
            2'b01:   return 2'b01;
            2'b10:   return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    function automatic logic [4:0] trap_of(input logic [4:0] fl, input logic [4:0] en);
        return fl & en;   // R8
    endfunction

    task automatic run_op(input logic [1:0] kind, input logic [4:0] en,
                          input logic [4:0] mfl, input logic [4:0] afl,
                          input int mlat, input int alat,
                          input logic [DW-1:0] a, input logic [DW-1:0] b,
                          input logic [DW-1:0] c, input logic [DW-1:0] pr,
                          input logic [DW-1:0] rs, input bit junk);
        logic [4:0] mt, at, ec;
        mt = trap_of(mfl, en);
        at = trap_of(afl, en);
        @(negedge clk);
        check(op_ready == 1'b1, "R1", "ready before offer", DW'(op_ready), 1);
        op_valid = 1'b1; op_kind = kind; op_a = a; op_b = b; op_c = c; trap_en = en;
        @(negedge clk);
        check(mul_req == 1'b1, "R1", "mul_req after accept", DW'(mul_req), 1);
        check(mul_a == a, "R1", "mul_a", mul_a, a);
        check(mul_b == b, "R1", "mul_b", mul_b, b);
        check(op_ready == 1'b0, "R1", "not ready when busy", DW'(op_ready), 0);
        if (junk) begin
            op_a = ~a; op_kind = ~kind; trap_en = ~en;   // offer ignored while busy (R1)
        end else begin
            op_valid = 1'b0;
        end
        for (int i = 0; i < mlat; i++) begin
            add_rsp_valid = junk; add_rsp_flags = 5'h1F;   // stray add response (R9)
            @(negedge clk);
            check(mul_req == 1'b0 && add_req == 1'b0 && done == 1'b0 && trap == 1'b0,
                  "R9", "quiet during multiply", DW'({mul_req, add_req, done, trap}), 0);
        end
        add_rsp_valid = 1'b0;
        mul_rsp_valid = 1'b1; mul_rsp_flags = mfl; mul_rsp_result = pr;
        @(negedge clk);
        mul_rsp_valid = 1'b0; op_valid = 1'b0;
        if (mt != 0) begin
            check(trap == 1'b1, "R4", "trap after multiply", DW'(trap), 1);
            check(add_req == 1'b0, "R4", "no add on multiply trap", DW'(add_req), 0);
            check(exc_cur == mt, "R4", "cur after multiply trap", DW'(exc_cur), DW'(mt));
            check(exc_acc == exp_acc, "R4", "acc held", DW'(exc_acc), DW'(exp_acc));
            check(rd_we == 1'b0, "R7", "no write on trap", DW'(rd_we), 0);
            @(negedge clk);
            check(trap == 1'b0 && op_ready == 1'b1, "R4", "trap one cycle",
                  DW'({trap, op_ready}), 1);
            return;
        end
        check(add_req == 1'b1, "R3", "add_req after clean multiply", DW'(add_req), 1);
        check(add_x == pr, "R3", "add_x is product", add_x, pr);
        check(add_y == c, "R3", "add_y is addend", add_y, c);
        check({add_neg_prod, add_neg_addend} == exp_signs(kind), "R2", "sign controls",
              DW'({add_neg_prod, add_neg_addend}), DW'(exp_signs(kind)));
        for (int i = 0; i < alat; i++) begin
            mul_rsp_valid = junk; mul_rsp_flags = 5'h1F;   // stray multiply response (R9)
            @(negedge clk);
            check(add_req == 1'b0 && done == 1'b0 && trap == 1'b0, "R9",
                  "quiet during add", DW'({add_req, done, trap}), 0);
        end
        mul_rsp_valid = 1'b0;
        add_rsp_valid = 1'b1; add_rsp_flags = afl; add_rsp_result = rs;
        @(negedge clk);
        add_rsp_valid = 1'b0;
        if (at != 0) begin
            check(trap == 1'b1 && done == 1'b0, "R5", "trap after add", DW'({trap, done}), 2);
            check(exc_cur == at, "R5", "cur holds only add trap bits", DW'(exc_cur), DW'(at));
            check(exc_acc == exp_acc, "R5", "acc held", DW'(exc_acc), DW'(exp_acc));
            check(rd_we == 1'b0, "R7", "no write on add trap", DW'(rd_we), 0);
        end else begin
            ec = mfl | afl;
            exp_acc = exp_acc | ec;
            check(done == 1'b1 && trap == 1'b0, "R6", "done pulse", DW'({done, trap}), 2);
            check(exc_cur == ec, "R6", "merged cur", DW'(exc_cur), DW'(ec));
            check(exc_acc == exp_acc, "R6", "accrued", DW'(exc_acc), DW'(exp_acc));
            check(rd_we == 1'b1, "R7", "write enable", DW'(rd_we), 1);
            check(rd_data == rs, "R7", "write data", rd_data, rs);
        end
        @(negedge clk);
        check(rd_we == 1'b0 && trap == 1'b0 && op_ready == 1'b1, "R7", "single-cycle end",
              DW'({rd_we, trap, op_ready}), 1);
    endtask

    task automatic idle_junk();
        logic [4:0] c0;
        c0 = exc_cur;
        @(negedge clk);
        mul_rsp_valid = 1'b1; mul_rsp_flags = 5'h1F;
        add_rsp_valid = 1'b1; add_rsp_flags = 5'h1F;
        @(negedge clk);
        mul_rsp_valid = 1'b0; add_rsp_valid = 1'b0;
        @(negedge clk);
        check(exc_cur == c0 && exc_acc == exp_acc, "R9", "idle responses ignored",
              DW'({exc_cur, exc_acc}), DW'({c0, exp_acc}));
        check(trap == 1'b0 && done == 1'b0 && mul_req == 1'b0 && add_req == 1'b0, "R9",
              "no pulses from idle responses", DW'({trap, done, mul_req, add_req}), 0);
    endtask

    function automatic logic [DW-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(op_ready == 1'b1, "R10", "ready after reset", DW'(op_ready), 1);
        check(exc_cur == 0 && exc_acc == 0, "R10", "fields cleared", DW'({exc_cur, exc_acc}), 0);
        check({mul_req, add_req, rd_we, done, trap} == 0, "R10", "pulses low",
              DW'({mul_req, add_req, rd_we, done, trap}), 0);

        // directed: each variant, clean, flags merged (R2, R6)
        for (int k = 0; k < 4; k++)
            run_op(2'(k), 5'h00, 5'h01, 5'h04, 1 + k, k, rnd64(), rnd64(), rnd64(),
                   rnd64(), rnd64(), 1'b0);
        // multiply trap on invalid (bit 4) enabled (R4, R8)
        run_op(2'b00, 5'b10000, 5'b10001, 5'h00, 0, 0, 64'h1, 64'h2, 64'h3, 64'h4, 64'h5, 1'b0);
        // non-enabled multiply flags do not trap (R8): divzero raised, only overflow enabled
        run_op(2'b01, 5'b01000, 5'b00010, 5'b00001, 2, 1, 64'hA, 64'hB, 64'hC, 64'hD, 64'hE, 1'b0);
        // add trap: overflow enabled, multiply inexact discarded (R5)
        run_op(2'b10, 5'b01000, 5'b00001, 5'b01001, 1, 2, 64'h11, 64'h22, 64'h33, 64'h44,
               64'h55, 1'b0);
        // busy offers and stray responses ignored (R1, R9)
        run_op(2'b11, 5'b00100, 5'b00001, 5'b00010, 3, 3, 64'h6, 64'h7, 64'h8, 64'h9, 64'hF,
               1'b1);
        idle_junk();

        for (int n = 0; n < 400; n++) begin
            logic [4:0] en;
            en = ($urandom % 3 == 0) ? 5'h00 : 5'($urandom);
            run_op(2'($urandom), en, 5'($urandom), 5'($urandom), int'($urandom % 4),
                   int'($urandom % 4), rnd64(), rnd64(), rnd64(), rnd64(), rnd64(),
                   1'($urandom % 4 == 0));
            if (n % 50 == 0) idle_junk();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule